// File: doc/BRIEF.md
# PLL Frequency-Word Hopping and Spread-Spectrum Controller

This block produces the 22-bit frequency word that sets the output frequency of one or more PLLs, with one channel per PLL. While a channel's ownership bit is set, the PLL follows the channel's internal current word. While the bit is clear, the PLL follows the static word that the surrounding logic supplies. Software loads a start word and then uses one of two modes.

- **Hop mode:** software names a target word. The current word then walks toward the target in bounded steps at a programmed rate, so the PLL never sees a large jump.
- **Spread-spectrum mode:** the current word sweeps in a triangle that runs from the loaded centre down to a programmed floor and back. The step size and the dwell time per step are programmable.

Software reaches every register through a plain single-cycle register bus. Read data comes back one cycle after the read strobe. A monitor register returns the live current word of each channel. A per-channel completion pulse marks the cycle in which a hop lands on its target.

Shared registers sit at byte offsets 0x00 (ownership), 0x08 (clock enable), 0x0C (reset control), 0x10 (slope 0) and 0x14 (slope 1). Channel `c` starts at byte address `CH_BASE + 0x20*c`. Within a channel the offsets are 0x00 CFG, 0x04 limit, 0x08 start, 0x0C target and 0x10 monitor.

Top module: `pll_hop_ctrl`

## Requirements
- R1: After the synchronous reset the block is in this state:
  - slope 0 and slope 1 read 0x06003C97;
  - the ownership, clock-enable and reset-control registers read 0, so every channel is held in reset;
  - every monitor reads 0;
  - `hop_done` is 0;
  - each `pll_word` slice equals its `static_word` slice from the second clock onward.
- R2: While ownership bit c is 0, `pll_word` slice c equals `static_word` slice c as it was one clock earlier. While the bit is 1, the slice equals channel c's current word as it was one clock earlier.
- R3: While reset-control bit c is 0, all registers of channel c read 0 and writes to them are ignored. Other channels are not affected.
- R4: A start write with bit 31 set loads bits 21:0 as both the current word and the centre; the start register reads back the centre. A start write with bit 31 clear has no effect.
- R5: A target write with bit 31 set, while CFG bits 0 and 2 are both set, starts a ramp. The ramp uses two values from slope 0:
  - the step S is bits 11:0, with 0 treated as 1;
  - the period P is bits 27:24, with 0 treated as 1.

  Every P clocks the word moves toward the target by S, or lands exactly on the target when the remaining distance is at most S. The word never passes the target. The landing edge is P*max(ceil(distance/S),1) clocks after the write edge.
- R6: On the landing edge `hop_done` goes high for exactly one cycle while the monitor equals the target, and the centre (start readback) takes the target value.
- R7: A target write with bit 31 set, while CFG bit 0 is set and bit 2 is clear, moves the word to the target at the write edge and pulses `hop_done` in the following cycle.
- R8: A target write with bit 31 set is stored but starts no movement while CFG bit 0 is clear. A target write with bit 31 clear changes neither the target readback nor the word.
- R9: With CFG bits 0 and 1 set, spread spectrum works as follows:
  - the step df is CFG bits 23:20, the dwell dt is CFG bits 19:16, and the limit L is bits 31:16 of the limit register;
  - the sweep starts one edge after the mode turns on;
  - the word waits dt+1 clocks before each step;
  - it steps down by df and is clamped at centre−L, where the direction turns;
  - it then steps up by df and is clamped at the centre, where the direction turns again.
- R10: When CFG bit 0 is cleared during a ramp, or bit 0 or bit 1 is cleared during a sweep, the word returns to the centre on the next edge and stays there.
- R11: While clock-enable bit c is 0, the ramp or sweep of channel c is frozen at its current word. When the bit is set again, movement resumes.
- R12: CFG and the limit register read back all 32 bits as written. The target register reads back bits 21:0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| static_word | input | NCH*DDS_W | Static PLL words, channel c in slice c |
| pll_word | output | NCH*DDS_W | Word driven to each PLL |
| hop_done | output | NCH | One-cycle pulse per channel when a hop lands |

## Verification
Three situations are the hardest to reach from the ports:

- **Sweep turn at the floor.** The sweep is clamped at the floor only when the limit is not a multiple of df. The bench therefore sets a limit of 30 with df 9 and dt 2. It predicts every cycle of the triangle from a bench-side model and compares it against `pll_word`, which lags the current word by one register.
- **Final partial ramp step.** A table of ramps covers the cases that exercise it: distances that leave a short final step, a full-scale downward walk, a zero slope treated as one, and a zero-distance hop. For each ramp the bench counts clocks from the write edge to the completion pulse.
- **Clock-enable freeze.** The bench drops the clock-enable bit in the middle of a ramp and reads the monitor twice, twenty clocks apart, to show that the word held still.

// File: rtl/pll_hop_pkg.sv
package pll_hop_pkg;
  // channel register offsets inside a 0x20-byte group
  localparam logic [4:0] OFF_CFG   = 5'h00;
  localparam logic [4:0] OFF_LMT   = 5'h04;
  localparam logic [4:0] OFF_START = 5'h08;
  localparam logic [4:0] OFF_TGT   = 5'h0C;
  localparam logic [4:0] OFF_MON   = 5'h10;
  localparam int CH_STRIDE_LG = 5;

  // shared register offsets
  localparam int SH_OWN  = 'h00;
  localparam int SH_CKEN = 'h08;
  localparam int SH_RSTC = 'h0C;
  localparam int SH_SLP0 = 'h10;
  localparam int SH_SLP1 = 'h14;

  localparam logic [31:0] SLOPE_RST = 32'h0600_3C97;

  typedef enum logic [1:0] {ST_IDLE, ST_RAMP, ST_SSC} eng_t;

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] lmt;
    logic [31:0] start;
    logic [31:0] tgt;
    logic [31:0] mon;
  } ch_view_t;

  function automatic logic [31:0] adiff(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? a - b : b - a;
  endfunction
endpackage

// File: rtl/hop_regbank.sv
module hop_regbank
  import pll_hop_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int ADDR_W  = 8,
  parameter int CH_BASE = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  ch_view_t [NCH-1:0]  views,
  output logic [NCH-1:0]      own_o,
  output logic [NCH-1:0]      cken_o,
  output logic [NCH-1:0]      rstc_o,
  output logic [11:0]         step_o,
  output logic [3:0]          per_o,
  output logic [NCH-1:0]      wr_cfg,
  output logic [NCH-1:0]      wr_lmt,
  output logic [NCH-1:0]      wr_start,
  output logic [NCH-1:0]      wr_tgt
);
  localparam int IDX_W = ADDR_W - CH_STRIDE_LG;

  logic [NCH-1:0]    own_q, cken_q, rstc_q;
  logic [31:0]       slp0_q, slp1_q;
  logic              in_ch;
  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic [4:0]        off;
  logic [31:0]       rd_val;

  assign in_ch = bus_addr >= ADDR_W'(CH_BASE);
  assign rel   = bus_addr - ADDR_W'(CH_BASE);
  assign idx   = rel[ADDR_W-1:CH_STRIDE_LG];
  assign off   = rel[4:0];

  // shared registers
  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= '0;
      cken_q <= '0;
      rstc_q <= '0;
      slp0_q <= SLOPE_RST;
      slp1_q <= SLOPE_RST;
    end else if (bus_wr && !in_ch) begin
      case (bus_addr)
        ADDR_W'(SH_OWN):  own_q  <= bus_wdata[NCH-1:0];
        ADDR_W'(SH_CKEN): cken_q <= bus_wdata[NCH-1:0];
        ADDR_W'(SH_RSTC): rstc_q <= bus_wdata[NCH-1:0];
        ADDR_W'(SH_SLP0): slp0_q <= bus_wdata;
        ADDR_W'(SH_SLP1): slp1_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  assert_rstc_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(SH_RSTC)) |=> rstc_q == $past(bus_wdata[NCH-1:0]));

  // per-channel write strobes
  for (genvar c = 0; c < NCH; c++) begin : g_strobe
    logic hit;
    assign hit         = bus_wr && in_ch && (idx == IDX_W'(c));
    assign wr_cfg[c]   = hit && (off == OFF_CFG);
    assign wr_lmt[c]   = hit && (off == OFF_LMT);
    assign wr_start[c] = hit && (off == OFF_START);
    assign wr_tgt[c]   = hit && (off == OFF_TGT);
  end

  assert_one_target_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_cfg, wr_lmt, wr_start, wr_tgt}));

  // read mux
  always_comb begin
    rd_val = '0;
    if (!in_ch) begin
      case (bus_addr)
        ADDR_W'(SH_OWN):  rd_val = 32'(own_q);
        ADDR_W'(SH_CKEN): rd_val = 32'(cken_q);
        ADDR_W'(SH_RSTC): rd_val = 32'(rstc_q);
        ADDR_W'(SH_SLP0): rd_val = slp0_q;
        ADDR_W'(SH_SLP1): rd_val = slp1_q;
        default: rd_val = '0;
      endcase
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (idx == IDX_W'(c)) begin
          case (off)
            OFF_CFG:   rd_val = views[c].cfg;
            OFF_LMT:   rd_val = views[c].lmt;
            OFF_START: rd_val = views[c].start;
            OFF_TGT:   rd_val = views[c].tgt;
            OFF_MON:   rd_val = views[c].mon;
            default:   rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign own_o  = own_q;
  assign cken_o = cken_q;
  assign rstc_o = rstc_q;
  assign step_o = slp0_q[11:0];
  assign per_o  = slp0_q[27:24];
endmodule

// File: rtl/hop_channel.sv
module hop_channel
  import pll_hop_pkg::*;
#(
  parameter int DDS_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ch_run,
  input  logic             ck_en,
  input  logic             own,
  input  logic             wr_cfg,
  input  logic             wr_lmt,
  input  logic             wr_start,
  input  logic             wr_tgt,
  input  logic [31:0]      wdata,
  input  logic [11:0]      slope_step,
  input  logic [3:0]       slope_per,
  input  logic [DDS_W-1:0] static_word,
  output logic [DDS_W-1:0] pll_word,
  output logic             hop_done,
  output ch_view_t         view
);
  localparam int CNT_W = 4;

  logic [31:0]      cfg_q, lmt_q;
  logic [DDS_W-1:0] centre_q, tgt_q, cur_q;
  eng_t             st_q;
  logic             up_q, dn_q;
  logic [CNT_W-1:0] cnt_q;

  logic [DDS_W-1:0] w_word, step_w, df_w, lim_w, floor_w, gap_w, ssc_next;
  logic [CNT_W-1:0] per_last, dt;
  logic             ssc_on, ld, trig, ssc_turn;

  assign w_word   = wdata[DDS_W-1:0];
  assign step_w   = (slope_step == '0) ? DDS_W'(1) : {{(DDS_W-12){1'b0}}, slope_step};
  assign per_last = (slope_per == '0) ? '0 : slope_per - 1'b1;
  assign df_w     = {{(DDS_W-4){1'b0}}, cfg_q[23:20]};
  assign dt       = cfg_q[19:16];
  assign lim_w    = {{(DDS_W-16){1'b0}}, lmt_q[31:16]};
  assign floor_w  = (centre_q > lim_w) ? centre_q - lim_w : '0;
  assign gap_w    = up_q ? tgt_q - cur_q : cur_q - tgt_q;
  assign ssc_on   = cfg_q[0] & cfg_q[1];
  assign ld       = wr_start & wdata[31];
  assign trig     = wr_tgt & wdata[31] & cfg_q[0];

  // next sweep value with clamping at the turn points
  always_comb begin
    ssc_turn = 1'b0;
    if (dn_q) begin
      if (cur_q <= floor_w || (cur_q - floor_w) <= df_w) begin
        ssc_next = floor_w;
        ssc_turn = 1'b1;
      end else begin
        ssc_next = cur_q - df_w;
      end
    end else begin
      if (cur_q >= centre_q || (centre_q - cur_q) <= df_w) begin
        ssc_next = centre_q;
        ssc_turn = 1'b1;
      end else begin
        ssc_next = cur_q + df_w;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ch_run) begin
      cfg_q    <= '0;
      lmt_q    <= '0;
      centre_q <= '0;
      tgt_q    <= '0;
      cur_q    <= '0;
      st_q     <= ST_IDLE;
      up_q     <= 1'b0;
      dn_q     <= 1'b1;
      cnt_q    <= '0;
      hop_done <= 1'b0;
    end else begin
      hop_done <= 1'b0;
      if (wr_cfg) cfg_q <= wdata;
      if (wr_lmt) lmt_q <= wdata;
      if (wr_tgt && wdata[31]) tgt_q <= w_word;
      if (ld) begin
        centre_q <= w_word;
        cur_q    <= w_word;
        st_q     <= ST_IDLE;
        cnt_q    <= '0;
      end else if (trig) begin
        cnt_q <= '0;
        if (cfg_q[2]) begin
          st_q <= ST_RAMP;
          up_q <= w_word > cur_q;
        end else begin
          cur_q    <= w_word;
          centre_q <= w_word;
          st_q     <= ST_IDLE;
          hop_done <= 1'b1;
        end
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (ssc_on) begin
              st_q  <= ST_SSC;
              cnt_q <= '0;
              dn_q  <= 1'b1;
              cur_q <= centre_q;
            end
          end
          ST_RAMP: begin
            if (!cfg_q[0]) begin
              st_q  <= ST_IDLE;
              cur_q <= centre_q;
            end else if (ck_en) begin
              if (cnt_q >= per_last) begin
                cnt_q <= '0;
                if (gap_w <= step_w) begin
                  cur_q    <= tgt_q;
                  centre_q <= tgt_q;
                  st_q     <= ST_IDLE;
                  hop_done <= 1'b1;
                end else begin
                  cur_q <= up_q ? cur_q + step_w : cur_q - step_w;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_SSC: begin
            if (!ssc_on) begin
              st_q  <= ST_IDLE;
              cur_q <= centre_q;
            end else if (ck_en) begin
              if (cnt_q >= dt) begin
                cnt_q <= '0;
                cur_q <= ssc_next;
                if (ssc_turn) dn_q <= ~dn_q;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pll_word <= '0;
    else     pll_word <= own ? cur_q : static_word;
  end

  assign view.cfg   = cfg_q;
  assign view.lmt   = lmt_q;
  assign view.start = {{(32-DDS_W){1'b0}}, centre_q};
  assign view.tgt   = {{(32-DDS_W){1'b0}}, tgt_q};
  assign view.mon   = {{(32-DDS_W){1'b0}}, cur_q};

  assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RAMP) |-> (up_q ? (cur_q <= tgt_q) : (cur_q >= tgt_q)));

  assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RAMP && ch_run && cfg_q[0] && !ld && !trig)
      |=> adiff(32'(cur_q), 32'($past(cur_q))) <= 32'($past(step_w)));

  assert_done_on_target_R6: assert property (@(posedge clk) disable iff (rst)
    hop_done |-> (cur_q == tgt_q && centre_q == tgt_q));

  assert_sweep_below_centre_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SSC) |-> cur_q <= centre_q);

  assert_held_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
    !ch_run |=> (cur_q == '0 && cfg_q == '0));

  assert_frozen_ramp_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RAMP && ch_run && cfg_q[0] && !ck_en && !ld && !trig) |=> $stable(cur_q));
endmodule

// File: rtl/pll_hop_ctrl.sv
module pll_hop_ctrl
  import pll_hop_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int DDS_W   = 22,
  parameter int ADDR_W  = 8,
  parameter int CH_BASE = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NCH*DDS_W-1:0]   static_word,
  output logic [NCH*DDS_W-1:0]   pll_word,
  output logic [NCH-1:0]         hop_done
);
  ch_view_t [NCH-1:0] views;
  logic [NCH-1:0]     own, cken, rstc, wr_cfg, wr_lmt, wr_start, wr_tgt;
  logic [11:0]        step;
  logic [3:0]         per;

  hop_regbank #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .views(views),
    .own_o(own), .cken_o(cken), .rstc_o(rstc), .step_o(step), .per_o(per),
    .wr_cfg(wr_cfg), .wr_lmt(wr_lmt), .wr_start(wr_start), .wr_tgt(wr_tgt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hop_channel #(.DDS_W(DDS_W)) u_ch (
      .clk(clk), .rst(rst), .ch_run(rstc[c]), .ck_en(cken[c]), .own(own[c]),
      .wr_cfg(wr_cfg[c]), .wr_lmt(wr_lmt[c]), .wr_start(wr_start[c]), .wr_tgt(wr_tgt[c]),
      .wdata(bus_wdata), .slope_step(step), .slope_per(per),
      .static_word(static_word[c*DDS_W +: DDS_W]),
      .pll_word(pll_word[c*DDS_W +: DDS_W]),
      .hop_done(hop_done[c]), .view(views[c])
    );

    assert_static_follow_R2: assert property (@(posedge clk) disable iff (rst)
      !own[c] |=> pll_word[c*DDS_W +: DDS_W] == $past(static_word[c*DDS_W +: DDS_W]));
  end
endmodule

// File: tb/pll_hop_ctrl_tb_top.sv
module pll_hop_ctrl_tb_top;
  localparam int NCH = 2;
  localparam int DW  = 22;
  localparam logic [DW-1:0] ST0 = 22'h0ABCDE;
  localparam logic [DW-1:0] ST1 = 22'h123456;

  // start, target, slope0, expected clocks from write edge to landing
  localparam logic [127:0] RAMP_TBL [0:4] = '{
    {32'h0000_1000, 32'h0000_1100, 32'h0200_0040, 32'd8},
    {32'h0000_2000, 32'h0000_1F00, 32'h0300_0030, 32'd18},
    {32'h003F_FFFF, 32'h0000_0000, 32'h0100_0FFF, 32'd1025},
    {32'h0000_0500, 32'h0000_0505, 32'h0000_0000, 32'd5},
    {32'h0000_0777, 32'h0000_0777, 32'h0400_0007, 32'd4}
  };

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NCH*DW-1:0] static_word = {ST1, ST0};
  logic [NCH*DW-1:0] pll_word;
  logic [NCH-1:0] hop_done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pll_hop_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .static_word(static_word),
    .pll_word(pll_word), .hop_done(hop_done)
  );

  function automatic logic [7:0] ca(input int c, input int off);
    return 8'(64 + 32 * c + off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(posedge clk);
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int ssc_off(input int k);
    int off = 0;
    bit dn = 1;
    for (int i = 0; i < k; i++) begin
      if (dn) begin
        if (30 - off <= 9) begin off = 30; dn = 0; end else off += 9;
      end else begin
        if (off <= 9) begin off = 0; dn = 1; end else off -= 9;
      end
    end
    return off;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v, m1, m2;
    int cnt;
    repeat (4) @(negedge clk);
    rst = 0;
    idle(3);
    // R1 reset state
    rd(8'h10, v); chk("R1 slope0", v, 32'h0600_3C97);
    rd(8'h14, v); chk("R1 slope1", v, 32'h0600_3C97);
    rd(8'h00, v); chk("R1 own", v, 0);
    rd(8'h08, v); chk("R1 cken", v, 0);
    rd(8'h0C, v); chk("R1 rstc", v, 0);
    rd(ca(0, 'h10), v); chk("R1 mon0", v, 0);
    chk("R1 pll0 static", 32'(pll_word[DW-1:0]), 32'(ST0));
    chk("R1 pll1 static", 32'(pll_word[2*DW-1:DW]), 32'(ST1));
    chk("R1 done", 32'(hop_done), 0);
    rd(8'h3C, v); chk("R12 unmapped", v, 0);

    // R3 held channel ignores writes
    wr(ca(0, 'h08), 32'h8000_1234);
    rd(ca(0, 'h08), v); chk("R3 start ignored", v, 0);

    wr(8'h0C, 3); wr(8'h08, 3); wr(8'h00, 1);
    // R4 load
    wr(ca(0, 'h08), 32'h0000_1234);
    rd(ca(0, 'h08), v); chk("R4 no bit31", v, 0);
    wr(ca(0, 'h08), 32'h8000_1234);
    rd(ca(0, 'h10), v); chk("R4 mon", v, 32'h1234);
    rd(ca(0, 'h08), v); chk("R4 centre", v, 32'h1234);
    idle(2);
    chk("R2 owned", 32'(pll_word[DW-1:0]), 32'h1234);
    chk("R2 static", 32'(pll_word[2*DW-1:DW]), 32'(ST1));

    // R12 readback on channel 1
    wr(ca(1, 'h00), 32'h0092_0005);
    rd(ca(1, 'h00), v); chk("R12 cfg1", v, 32'h0092_0005);
    wr(ca(1, 'h04), 32'h001E_ABCD);
    rd(ca(1, 'h04), v); chk("R12 lmt1", v, 32'h001E_ABCD);
    rd(ca(0, 'h10), v); chk("R12 ch0 untouched", v, 32'h1234);

    // R5 / R6 ramp table
    for (int r = 0; r < 5; r++) begin
      logic [31:0] s, t, sl, cyc;
      {s, t, sl, cyc} = RAMP_TBL[r];
      wr(8'h10, sl);
      wr(ca(0, 'h00), 32'h5);
      wr(ca(0, 'h08), 32'h8000_0000 | s);
      wr(ca(0, 'h0C), 32'h8000_0000 | t);
      cnt = 0;
      while (!hop_done[0] && cnt < 3000) begin @(negedge clk); cnt++; end
      chk($sformatf("R5 row%0d clocks", r), cnt, cyc);
      @(negedge clk);
      chk($sformatf("R6 row%0d pulse width", r), 32'(hop_done[0]), 0);
      rd(ca(0, 'h10), v); chk($sformatf("R5 row%0d mon", r), v, t);
      rd(ca(0, 'h08), v); chk($sformatf("R6 row%0d centre", r), v, t);
    end

    // R8 trigger with control off; write without bit31
    wr(ca(0, 'h00), 32'h0);
    wr(ca(0, 'h0C), 32'h8000_2000);
    idle(10);
    rd(ca(0, 'h10), v); chk("R8 disabled no move", v, 32'h777);
    wr(ca(0, 'h00), 32'h5);
    wr(ca(0, 'h0C), 32'h0000_2500);
    idle(10);
    rd(ca(0, 'h0C), v); chk("R8 target kept", v, 32'h2000);
    rd(ca(0, 'h10), v); chk("R8 mon kept", v, 32'h777);

    // R7 immediate hop
    wr(ca(0, 'h00), 32'h1);
    wr(ca(0, 'h0C), 32'h8000_3333);
    chk("R7 done pulse", 32'(hop_done[0]), 1);
    rd(ca(0, 'h10), v); chk("R7 mon", v, 32'h3333);

    // R11 clock enable freeze
    wr(8'h10, 32'h0100_0001);
    wr(ca(0, 'h00), 32'h5);
    wr(ca(0, 'h08), 32'h8000_0100);
    wr(ca(0, 'h0C), 32'h8000_0200);
    idle(10);
    wr(8'h08, 2);
    idle(2);
    rd(ca(0, 'h10), m1);
    idle(20);
    rd(ca(0, 'h10), m2);
    chk("R11 frozen", m2, m1);
    chk("R11 mid ramp", 32'(m1 > 32'h100 && m1 < 32'h200), 1);
    wr(8'h08, 3);
    cnt = 0;
    while (!hop_done[0] && cnt < 400) begin @(negedge clk); cnt++; end
    chk("R11 resumed", 32'(hop_done[0]), 1);
    rd(ca(0, 'h10), v); chk("R11 mon", v, 32'h200);

    // R10 ramp abort
    wr(ca(0, 'h08), 32'h8000_0400);
    wr(ca(0, 'h0C), 32'h8000_0800);
    idle(10);
    wr(ca(0, 'h00), 32'h4);
    idle(2);
    rd(ca(0, 'h10), v); chk("R10 abort centre", v, 32'h400);
    idle(10);
    rd(ca(0, 'h10), v); chk("R10 abort held", v, 32'h400);

    // R9 spread spectrum sweep, df=9 dt=2 limit=30
    wr(ca(0, 'h00), 32'h1);
    wr(ca(0, 'h08), 32'h8001_0000);
    wr(ca(0, 'h04), 32'h001E_0000);
    wr(ca(0, 'h00), 32'h0092_0003);
    for (int j = 1; j <= 30; j++) begin
      int k;
      @(negedge clk);
      k = (j < 2) ? 0 : (j - 2) / 3;
      chk($sformatf("R9 sweep j%0d", j), 32'(pll_word[DW-1:0]), 32'h1_0000 - 32'(ssc_off(k)));
    end
    // R10 stop sweep
    wr(ca(0, 'h00), 32'h1);
    idle(2);
    chk("R10 sweep stop", 32'(pll_word[DW-1:0]), 32'h1_0000);
    idle(10);
    chk("R10 sweep held", 32'(pll_word[DW-1:0]), 32'h1_0000);

    // R3 hold channel 0 again
    wr(8'h0C, 2);
    idle(2);
    rd(ca(0, 'h00), v); chk("R3 cfg cleared", v, 0);
    rd(ca(0, 'h10), v); chk("R3 mon cleared", v, 0);
    chk("R3 pll0 zero", 32'(pll_word[DW-1:0]), 0);
    rd(ca(1, 'h00), v); chk("R3 ch1 kept", v, 32'h0092_0005);
    chk("R2 ch1 static", 32'(pll_word[2*DW-1:DW]), 32'(ST1));

    summary();
  end
endmodule